// File: doc/BRIEF.md
# Serial Register-Control Slave

This block is a slave on a four-wire serial control bus made of a chip select, a serial clock, a data input and a data output. It holds a file of 32 eight-bit control registers. Other logic in the chip reads the registers as one flat vector. A bus master writes or reads one register per 16-bit frame. The frame is sent most significant bit first and carries a two-bit chip address, a direction flag, a five-bit register address and an eight-bit data byte.

All bus pins are brought into the system clock through synchronizer chains. Edges of the serial clock and chip select are detected in the system clock domain, so the system clock must run at least four times faster than the serial clock. Write data takes effect only when chip select is released after a complete frame. Read data is shifted out during the data half of the frame. The output enable is kept low at every other time, so that a pad can leave the line floating.

A power-down input, active low, forces every register to its default value asynchronously. The separate active-low reset clears only the frame logic. Bit 0 of register 0 acts as a run flag for the chip's timing logic. Software clears it to hold that logic in reset, and the stored register contents stay as they are.

Top module: `ser_reg_ctrl`

## Requirements
- R1: A frame is 16 bits, MSB first: bit 15 = C1, bit 14 = C0, bit 13 = direction (1 = write), bits 12..8 = register address, bits 7..0 = data. Each bit is sampled on a rising serial clock. A write frame updates the addressed register only after chip select goes high, never before.
- R2: A frame is accepted only when C1 = 1 and C0 equals `chip_sel_i`. Any other frame leaves every register unchanged and never enables the data output.
- R3: In an accepted read frame (direction = 0), the data output carries bits 7..0 of the addressed register in bit slots 8..15. Each bit changes after a falling serial clock and is valid before the next rising edge. The output enable is high in every one of those slots.
- R4: `sdo_oe_o` is low out of reset, during header slots 0..7, and within a few system clocks after chip select goes high.
- R5: If chip select goes high after fewer or more than 16 rising serial clocks, the frame is aborted and no register changes.
- R6: While `pwrdn_ni` is low, every register n holds its default value. That value is n, except register 0, whose default is 8'h01.
- R7: `timing_run_o` follows bit 0 of register 0. Writing a value with bit 0 = 0 drives it low and leaves all other registers unchanged.
- R8: `regs_o[8n+7:8n]` is the content of register n.
- R9: `rst_ni` low resets only the frame logic. Register contents survive it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset of frame logic |
| pwrdn_ni | input | 1 | Active-low asynchronous power-down, loads register defaults |
| chip_sel_i | input | 1 | Strap value the C0 address bit must match |
| csn_i | input | 1 | Bus chip select, active low |
| sclk_i | input | 1 | Bus serial clock |
| sdi_i | input | 1 | Bus serial data in |
| sdo_o | output | 1 | Bus serial data out |
| sdo_oe_o | output | 1 | Output enable for the data-out pad |
| regs_o | output | 256 | Flat register file contents |
| timing_run_o | output | 1 | Run flag for the chip's timing logic (low = held in reset) |

## Verification
Every bus pin passes through a two-stage synchronizer and then one edge-detect compare. Any action on a pin change therefore lands on the third system clock edge after the change. This holds for a shifted-in bit, a data-out update after a falling serial clock, the output-enable drop after chip select rises, and the register commit. The bench holds each serial clock phase and each chip-select transition for eight system clocks and samples only at the end of that window, well after the due edge. It checks read data just before the rising serial edge, as a master would. It checks each write twice: the register value just before chip select rises, where the old value is expected, and eight clocks after, where the new value is expected.

// File: rtl/ser_reg_pkg.sv
package ser_reg_pkg;
  localparam logic CHIP_HI = 1'b1;   // fixed upper chip-address bit
  localparam int unsigned CTL_W = 3; // C1, C0, direction

  // Default content: register index, with the run bit forced high.
  function automatic logic [31:0] reg_dflt(input int unsigned idx,
                                           input int unsigned run_reg,
                                           input int unsigned run_bit);
    logic [31:0] v;
    v = idx;
    if (idx == run_reg) v[run_bit[4:0]] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff_q <= {STAGES{RST_VAL}};
    end else begin
      ff_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) ff_q[i] <= ff_q[i-1];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/ser_frame.sv
module ser_frame
  import ser_reg_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_s_i,
  input  logic              sclk_s_i,
  input  logic              sdi_s_i,
  input  logic              chip_sel_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              wr_en_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int unsigned HDR_W   = CTL_W + ADDR_W;
  localparam int unsigned FRAME_W = HDR_W + DATA_W;
  localparam int unsigned SH_W    = (HDR_W > DATA_W) ? HDR_W : DATA_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 2);
  localparam int unsigned IDX_W   = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic             csn_d, sclk_d;
  logic             csn_rise, sclk_rise, sclk_fall;
  logic [CNT_W-1:0] cnt_q;
  logic [SH_W-1:0]  sh_q;
  logic [HDR_W-1:0] hdr_q;
  logic             hdr_vld_q;
  logic             hit, is_wr, rd_act, in_data;
  logic [IDX_W-1:0] bit_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csn_d  <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      csn_d  <= csn_s_i;
      sclk_d <= sclk_s_i;
    end
  end

  assign csn_rise  = csn_s_i & ~csn_d;
  assign sclk_rise = ~csn_s_i & sclk_s_i & ~sclk_d;
  assign sclk_fall = ~csn_s_i & ~sclk_s_i & sclk_d;

  // Bit counter saturates one past a full frame to flag overlong frames.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      sh_q      <= '0;
      hdr_q     <= '0;
      hdr_vld_q <= 1'b0;
    end else if (csn_s_i) begin
      cnt_q     <= '0;
      hdr_vld_q <= 1'b0;
    end else if (sclk_rise) begin
      sh_q <= {sh_q[SH_W-2:0], sdi_s_i};
      if (cnt_q <= CNT_W'(FRAME_W)) cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(HDR_W - 1)) begin
        hdr_q     <= {sh_q[HDR_W-2:0], sdi_s_i};
        hdr_vld_q <= 1'b1;
      end
    end
  end

  assign hit    = hdr_vld_q & (hdr_q[HDR_W-1] == CHIP_HI) & (hdr_q[HDR_W-2] == chip_sel_i);
  assign is_wr  = hdr_q[HDR_W-3];
  assign rd_act = hit & ~is_wr;
  assign addr_o = hdr_q[ADDR_W-1:0];
  assign wdata_o = sh_q[DATA_W-1:0];
  assign wr_en_o = csn_rise & hit & is_wr & (cnt_q == CNT_W'(FRAME_W));

  assign in_data = (cnt_q >= CNT_W'(HDR_W)) & (cnt_q < CNT_W'(FRAME_W));
  assign bit_idx = IDX_W'(HDR_W + DATA_W - 1 - int'(cnt_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sdo_o    <= 1'b0;
      sdo_oe_o <= 1'b0;
    end else if (csn_s_i) begin
      sdo_o    <= 1'b0;
      sdo_oe_o <= 1'b0;
    end else if (sclk_fall && rd_act && in_data) begin
      sdo_o    <= rd_data_i[bit_idx];
      sdo_oe_o <= 1'b1;
    end
  end
endmodule

// File: rtl/ser_regfile.sv
module ser_regfile
  import ser_reg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned RUN_REG = 0,
  parameter int unsigned RUN_BIT = 0,
  localparam int unsigned NREG   = 1 << ADDR_W
) (
  input  logic                   clk_i,
  input  logic                   pwrdn_ni,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic [NREG*DATA_W-1:0] regs_o
);
  logic [DATA_W-1:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DATA_W-1:0] DFLT = DATA_W'(reg_dflt(g, RUN_REG, RUN_BIT));
    always_ff @(posedge clk_i or negedge pwrdn_ni) begin
      if (!pwrdn_ni)                                  mem[g] <= DFLT;
      else if (wr_en_i && wr_addr_i == ADDR_W'(g))    mem[g] <= wr_data_i;
    end
    assign regs_o[g*DATA_W +: DATA_W] = mem[g];
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/ser_reg_ctrl.sv
module ser_reg_ctrl
  import ser_reg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RUN_REG     = 0,
  parameter int unsigned RUN_BIT     = 0,
  localparam int unsigned NREG       = 1 << ADDR_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   pwrdn_ni,
  input  logic                   chip_sel_i,
  input  logic                   csn_i,
  input  logic                   sclk_i,
  input  logic                   sdi_i,
  output logic                   sdo_o,
  output logic                   sdo_oe_o,
  output logic [NREG*DATA_W-1:0] regs_o,
  output logic                   timing_run_o
);
  logic [2:0]        pin_raw, pin_syn;
  logic              csn_s, sclk_s, sdi_s;
  logic              wr_en;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata, rdata;

  assign pin_raw = {sdi_i, sclk_i, csn_i};

  // Index 0 is chip select, which idles high.
  for (genvar g = 0; g < 3; g++) begin : g_sync
    ser_sync #(.STAGES(SYNC_STAGES), .RST_VAL(g == 0)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pin_raw[g]),
      .q_o    (pin_syn[g])
    );
  end

  assign csn_s  = pin_syn[0];
  assign sclk_s = pin_syn[1];
  assign sdi_s  = pin_syn[2];

  ser_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .csn_s_i    (csn_s),
    .sclk_s_i   (sclk_s),
    .sdi_s_i    (sdi_s),
    .chip_sel_i (chip_sel_i),
    .rd_data_i  (rdata),
    .addr_o     (addr),
    .wdata_o    (wdata),
    .wr_en_o    (wr_en),
    .sdo_o      (sdo_o),
    .sdo_oe_o   (sdo_oe_o)
  );

  ser_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RUN_REG(RUN_REG), .RUN_BIT(RUN_BIT)) u_regs (
    .clk_i     (clk_i),
    .pwrdn_ni  (pwrdn_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (addr),
    .wr_data_i (wdata),
    .rd_addr_i (addr),
    .rd_data_o (rdata),
    .regs_o    (regs_o)
  );

  assign timing_run_o = regs_o[RUN_REG*DATA_W + RUN_BIT];
endmodule

// File: rtl/ser_reg_ctrl_chk.sv
module ser_reg_ctrl_chk
  import ser_reg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned RUN_REG = 0,
  parameter int unsigned RUN_BIT = 0,
  localparam int unsigned NREG   = 1 << ADDR_W
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   pwrdn_ni,
  input logic                   csn_s,
  input logic                   wr_en,
  input logic                   sdo_oe_o,
  input logic [NREG*DATA_W-1:0] regs_o,
  input logic                   timing_run_o
);
  logic [NREG*DATA_W-1:0] dflt_flat;
  for (genvar g = 0; g < NREG; g++) begin : g_dflt
    assign dflt_flat[g*DATA_W +: DATA_W] = DATA_W'(reg_dflt(g, RUN_REG, RUN_BIT));
  end

  p_wr_at_csn_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> csn_s);

  p_wr_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> !wr_en);

  p_regs_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !pwrdn_ni)
    !wr_en |=> $stable(regs_o));

  p_oe_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_s |=> !sdo_oe_o);

  p_pdn_dflt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwrdn_ni |-> regs_o == dflt_flat);

  p_run_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || !pwrdn_ni)
    $fell(timing_run_o) |-> $past(wr_en));
endmodule

bind ser_reg_ctrl ser_reg_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RUN_REG(RUN_REG), .RUN_BIT(RUN_BIT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pwrdn_ni     (pwrdn_ni),
  .csn_s        (csn_s),
  .wr_en        (wr_en),
  .sdo_oe_o     (sdo_oe_o),
  .regs_o       (regs_o),
  .timing_run_o (timing_run_o)
);

// File: tb/tb_ser_reg_ctrl.sv
module tb_ser_reg_ctrl;
  localparam int CLK_P = 10;
  localparam int H     = 8;   // system clocks per serial half period

  logic         clk = 1'b0;
  logic         rst_n, pwrdn_n, chip_sel, csn, sclk, sdi;
  logic         sdo, sdo_oe, run;
  logic [255:0] regs, pre_regs;
  logic [7:0]   exp_r [32];
  int           nchk = 0, nfail = 0;
  bit           done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ser_reg_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .pwrdn_ni(pwrdn_n), .chip_sel_i(chip_sel),
    .csn_i(csn), .sclk_i(sclk), .sdi_i(sdi), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .regs_o(regs), .timing_run_o(run)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] dflt(input int a);
    return (a == 0) ? 8'h01 : 8'(a);
  endfunction

  function automatic int mismatches();
    int n = 0;
    for (int a = 0; a < 32; a++) if (regs[a*8 +: 8] !== exp_r[a]) n++;
    return n;
  endfunction

  function automatic logic [31:0] mk(input bit c1, input bit c0, input bit w,
                                     input int a, input logic [7:0] d);
    logic [4:0] a5 = 5'(a);
    return {c1, c0, w, a5, d, 16'h0};
  endfunction

  task automatic run_frame(input logic [31:0] f, input int nbits, output logic [7:0] rd,
                           output int oe_hdr, output int oe_dat);
    rd = '0; oe_hdr = 0; oe_dat = 0;
    csn = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = f[31-i];
      repeat (H) @(negedge clk);
      if (i < 8) begin
        if (sdo_oe) oe_hdr++;
      end else if (i < 16) begin
        if (sdo_oe) oe_dat++;
        rd[15-i] = sdo;
      end
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    pre_regs = regs;
    csn = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  initial begin
    logic [7:0] rd, d;
    int oh, od;
    rst_n = 0; pwrdn_n = 0; chip_sel = 1; csn = 1; sclk = 0; sdi = 0;
    repeat (5) @(negedge clk);
    rst_n = 1; pwrdn_n = 1;
    repeat (4) @(negedge clk);
    for (int a = 0; a < 32; a++) exp_r[a] = dflt(a);

    // R6 R8: defaults after power-down, flat layout
    for (int a = 0; a < 32; a++) check(regs[a*8 +: 8] === exp_r[a], "R8 reset default", regs[a*8 +: 8], exp_r[a]);
    check(sdo_oe === 1'b0, "R4 reset oe", sdo_oe, 0);
    check(run === 1'b1, "R7 reset run", run, 1);

    for (int s = 0; s < 2; s++) begin
      chip_sel = s[0];
      for (int a = 0; a < 32; a++) begin
        d = 8'((a * 37 + s * 91 + 5) & 255) | 8'(a == 0);
        run_frame(mk(1, s[0], 1, a, d), 16, rd, oh, od);
        check(pre_regs[a*8 +: 8] === exp_r[a], "R1 no early commit", pre_regs[a*8 +: 8], exp_r[a]);
        exp_r[a] = d;
        check(regs[a*8 +: 8] === d, "R1 write commit", regs[a*8 +: 8], d);
        check(oh == 0 && od == 0, "R4 oe in write", oh + od, 0);
      end
      check(mismatches() == 0, "R1 file after sweep", mismatches(), 0);
      for (int a = 0; a < 32; a++) begin
        run_frame(mk(1, s[0], 0, a, 8'h00), 16, rd, oh, od);
        check(rd === exp_r[a], "R3 read data", rd, exp_r[a]);
        check(od == 8, "R3 oe in data slots", od, 8);
        check(oh == 0, "R4 oe in header", oh, 0);
        check(sdo_oe === 1'b0, "R4 oe after csn", sdo_oe, 0);
      end
    end

    // R2: wrong chip address
    chip_sel = 1'b0;
    run_frame(mk(0, 0, 1, 3, 8'h5A), 16, rd, oh, od);
    check(mismatches() == 0, "R2 C1=0 write", mismatches(), 0);
    run_frame(mk(1, 1, 1, 4, 8'h5A), 16, rd, oh, od);
    check(mismatches() == 0, "R2 C0 mismatch write", mismatches(), 0);
    run_frame(mk(1, 1, 0, 4, 8'h00), 16, rd, oh, od);
    check(oh + od == 0, "R2 C0 mismatch read oe", oh + od, 0);
    run_frame(mk(0, 0, 0, 4, 8'h00), 16, rd, oh, od);
    check(oh + od == 0, "R2 C1=0 read oe", oh + od, 0);

    // R5: short and long frames
    run_frame(mk(1, 0, 1, 6, 8'hC3), 10, rd, oh, od);
    check(mismatches() == 0, "R5 short 10", mismatches(), 0);
    run_frame(mk(1, 0, 1, 6, 8'hC3), 15, rd, oh, od);
    check(mismatches() == 0, "R5 short 15", mismatches(), 0);
    run_frame(mk(1, 0, 1, 6, 8'hC3), 17, rd, oh, od);
    check(mismatches() == 0, "R5 long 17", mismatches(), 0);

    // R7: run bit clear and set
    run_frame(mk(1, 0, 1, 0, 8'hA4), 16, rd, oh, od);
    exp_r[0] = 8'hA4;
    check(run === 1'b0, "R7 run low", run, 0);
    check(mismatches() == 0, "R7 others kept", mismatches(), 0);
    run_frame(mk(1, 0, 0, 0, 8'h00), 16, rd, oh, od);
    check(rd === 8'hA4, "R7 reg0 readback", rd, 8'hA4);
    run_frame(mk(1, 0, 1, 0, 8'hA5), 16, rd, oh, od);
    exp_r[0] = 8'hA5;
    check(run === 1'b1, "R7 run high", run, 1);

    // R9: frame reset keeps registers
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(mismatches() == 0, "R9 regs kept", mismatches(), 0);
    run_frame(mk(1, 0, 0, 9, 8'h00), 16, rd, oh, od);
    check(rd === exp_r[9], "R9 read after reset", rd, exp_r[9]);

    // R6: power-down restores defaults
    pwrdn_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int a = 0; a < 32; a++) exp_r[a] = dflt(a);
    check(mismatches() == 0, "R6 during power-down", mismatches(), 0);
    pwrdn_n = 1'b1;
    repeat (2) @(negedge clk);
    check(mismatches() == 0, "R6 after power-down", mismatches(), 0);
    run_frame(mk(1, 0, 0, 17, 8'h00), 16, rd, oh, od);
    check(rd === 8'd17, "R6 read default", rd, 17);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule